// File: doc/BRIEF.md
# Output Gating and Timing-Code Framer

This block sits at the very end of a video output path. It takes a byte stream that arrives at irregular moments and frames it for a downstream video port. Each input byte comes with a valid flag, a start-of-line and an end-of-line marker, and the field and vertical-blanking state of its line.

The framer produces these outputs:
- the data bus;
- a per-clock qualifier, which marks the cycles that carry real data;
- a horizontal and a vertical reference output. Each is either an active-high gate or a one-clock pulse on the gate's rising edge.

When enabled, the framer also embeds four-byte start-of-active-video and end-of-active-video timing codes of the BT.656 kind around each line. A configuration bit chooses what the bus carries on cycles that hold neither data nor code bytes.

Every byte goes through a fixed delay that equals the length of a timing code. This leaves room to place a start code directly in front of the first byte of a line without stalling the source. The stream is not buffered beyond that delay.

Top module: `vport_framer`

## Requirements
- R1: While reset is asserted, `out_data`, `out_qual`, `out_href` and `out_vref` are all 0.
- R2: An input byte with `in_valid` high that is sampled at clock edge k appears on `out_data` after edge k+4, with `out_qual` high. `out_qual` is low on every other cycle.
- R3: In gate mode (`cfg_pulse_mode` = 0), `out_href` is high from the output cycle of a line's first valid byte through the output cycle of its last valid byte. This includes unqualified gap cycles inside the line. It is low elsewhere.
- R4: In gate mode, `out_vref` changes only in the output cycle of a line's first valid byte. It goes high there if that line's `in_vblank` is 0 and low if it is 1.
- R5: With `cfg_pulse_mode` = 1, `out_href` and `out_vref` are high for exactly one cycle, in the cycle in which the corresponding gate would rise. They stay low while that gate stays high.
- R6: With `cfg_code_en` = 1, the four output cycles just before a line's first data byte carry FF, 00, 00, XY with H = 0. F and V come from that line's `in_field` and `in_vblank`. `out_qual` and the gate-mode `out_href` are low in those cycles.
- R7: With `cfg_code_en` = 1, the four output cycles just after a line's last data byte carry FF, 00, 00, XY with H = 1 and with that line's F and V. `out_qual` is low in those cycles.
- R8: The code byte XY is, MSB first, {1, F, V, H, V^H, F^H, F^V, F^V^H}. For example: F0 V0 start = 0x80, F0 V0 end = 0x9D, F1 V1 start = 0xEC, F1 V1 end = 0xF1, F1 V0 start = 0xC7.
- R9: With `cfg_code_en` = 0, no code bytes are inserted. The cycles around a line carry the filler value.
- R10: With `cfg_blank_fill` = 0, every cycle that carries neither data nor a code byte outputs 0x00.
- R11: With `cfg_blank_fill` = 1, those filler cycles output 0x80 and 0x10 in turn. The first filler after reset is 0x80. The alternation advances only on filler cycles, so code and data bytes do not break it.
- R12: Valid bytes occur only from a line's start marker through its end marker. The source leaves at least 8 idle cycles between a line's last byte and the next line's first byte. At exactly that spacing, the end code of one line and the start code of the next follow each other without overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_sol | input | 1 | Byte is the first of its line |
| in_eol | input | 1 | Byte is the last of its line |
| in_field | input | 1 | Field identity of the line |
| in_vblank | input | 1 | Line lies in vertical blanking |
| cfg_pulse_mode | input | 1 | 1: references are one-clock pulses; 0: gates |
| cfg_code_en | input | 1 | 1: insert start/end timing codes |
| cfg_blank_fill | input | 1 | 1: alternating blanking filler; 0: zero filler |
| out_data | output | 8 | Output bus |
| out_qual | output | 1 | Output bus carries a data byte |
| out_href | output | 1 | Horizontal gate or pulse |
| out_vref | output | 1 | Vertical gate or pulse |

## Verification
Two things can land on adjacent cycles: a line's end code and the next line's start code. There are two ways to provoke this. One is a one-byte line, whose start marker and end marker sit on the same byte. The other is a pair of lines separated by exactly the minimum of eight idle cycles, so that the last end-code byte and the first start-code byte are neighbours. The bench judges both by the exact byte sequence, qualifier and horizontal gate on each of those cycles. It also checks that the filler alternation resumes across code bytes and across gap cycles inside a line.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    localparam int BYTE_W   = 8;
    localparam int CODE_LEN = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              sol;
        logic              eol;
        logic              fld;
        logic              vblk;
    } beat_t;

    // XY word of a timing code with its protection bits
    function automatic logic [BYTE_W-1:0] code_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction
endpackage

// File: rtl/vpf_delay.sv
module vpf_delay
    import vpf_pkg::*;
#(
    parameter int DEPTH = CODE_LEN
) (
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t din,
    output beat_t dout
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        beat_t stage_d;
        beat_t stage_q;
        if (g == 0) begin : g_head
            always_comb stage_d = din;
        end else begin : g_link
            always_comb stage_d = g_stage[g-1].stage_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end
    end

    assign dout = g_stage[DEPTH-1].stage_q;
endmodule

// File: rtl/vpf_code_seq.sv
module vpf_code_seq
    import vpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sav_go,
    input  logic              eav_go,
    input  logic              fld,
    input  logic              vblk,
    output logic              active,
    output logic [BYTE_W-1:0] code_byte
);
    localparam int IDX_W = $clog2(CODE_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

    typedef struct packed {
        logic              run;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] xy;
    } seq_t;

    seq_t q, d;
    logic [IDX_W-1:0] pos;

    always_comb begin
        d      = q;
        active = 1'b0;
        pos    = '0;
        if (sav_go || eav_go) begin
            active = 1'b1;
            d.run  = 1'b1;
            d.idx  = IDX_W'(1);
            d.xy   = code_xy(fld, vblk, eav_go);
        end else if (q.run) begin
            active = 1'b1;
            pos    = q.idx;
            d.idx  = q.idx + IDX_W'(1);
            if (q.idx == LAST_IDX) d.run = 1'b0;
        end
        if (pos == '0)            code_byte = '1;
        else if (pos == LAST_IDX) code_byte = q.xy;
        else                      code_byte = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12
    no_code_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_go || eav_go) |-> (!q.run && !(sav_go && eav_go)));
endmodule

// File: rtl/vpf_gates.sv
module vpf_gates (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_start,
    input  logic beat_end,
    input  logic beat_vblk,
    input  logic pulse_mode,
    output logic h_out,
    output logic v_out
);
    typedef struct packed {
        logic hg;
        logic vg;
        logic end_seen;
        logic h;
        logic v;
    } gate_t;

    gate_t q, d;

    always_comb begin
        d          = q;
        d.end_seen = beat_end;
        d.hg       = beat_start | (q.hg & ~q.end_seen);
        d.vg       = beat_start ? ~beat_vblk : q.vg;
        d.h        = pulse_mode ? (d.hg & ~q.hg) : d.hg;
        d.v        = pulse_mode ? (d.vg & ~q.vg) : d.vg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign h_out = q.h;
    assign v_out = q.v;

    // R4
    vgate_moves_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.vg) |-> $past(beat_start));

    // R5
    hpulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && q.h) |=> (!q.h || !pulse_mode));
endmodule

// File: rtl/vport_framer.sv
module vport_framer
    import vpf_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL_A = 8'h80,
    parameter logic [BYTE_W-1:0] FILL_B = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic              in_field,
    input  logic              in_vblank,
    input  logic              cfg_pulse_mode,
    input  logic              cfg_code_en,
    input  logic              cfg_blank_fill,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_qual,
    output logic              out_href,
    output logic              out_vref
);
    localparam int LAT = CODE_LEN;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              qual;
        logic              code;
        logic              fill;
        logic              phase;
        logic              eol;
        logic              fld;
        logic              vblk;
    } out_t;

    out_t              q, d;
    beat_t             in_beat, tail;
    logic              sav_go, eav_go, seq_act, seq_fld, seq_vblk;
    logic [BYTE_W-1:0] seq_byte;

    assign in_beat = {in_data, in_valid, in_sol, in_eol, in_field, in_vblank};

    vpf_delay #(.DEPTH(LAT)) u_delay (
        .clk (clk),
        .rst_n (rst_n),
        .din (in_beat),
        .dout (tail)
    );

    assign sav_go   = cfg_code_en & in_valid & in_sol;
    assign eav_go   = cfg_code_en & q.eol;
    assign seq_fld  = sav_go ? in_field  : q.fld;
    assign seq_vblk = sav_go ? in_vblank : q.vblk;

    vpf_code_seq u_seq (
        .clk (clk),
        .rst_n (rst_n),
        .sav_go (sav_go),
        .eav_go (eav_go),
        .fld (seq_fld),
        .vblk (seq_vblk),
        .active (seq_act),
        .code_byte (seq_byte)
    );

    vpf_gates u_gates (
        .clk (clk),
        .rst_n (rst_n),
        .beat_start (tail.valid & tail.sol),
        .beat_end (tail.valid & tail.eol),
        .beat_vblk (tail.vblk),
        .pulse_mode (cfg_pulse_mode),
        .h_out (out_href),
        .v_out (out_vref)
    );

    always_comb begin
        d      = q;
        d.eol  = tail.valid & tail.eol;
        d.fld  = tail.fld;
        d.vblk = tail.vblk;
        d.code = 1'b0;
        d.fill = 1'b0;
        d.qual = 1'b0;
        if (seq_act) begin
            d.data = seq_byte;
            d.code = 1'b1;
        end else if (tail.valid) begin
            d.data = tail.data;
            d.qual = 1'b1;
        end else begin
            d.fill  = 1'b1;
            d.data  = cfg_blank_fill ? (q.phase ? FILL_B : FILL_A) : '0;
            d.phase = ~q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_data = q.data;
    assign out_qual = q.qual;

    // R3
    hgate_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.qual && !cfg_pulse_mode && !$past(cfg_pulse_mode)) |-> out_href);

    // R6
    code_outside_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.code && !cfg_pulse_mode && !$past(cfg_pulse_mode)) |-> !out_href);

    // R11
    fill_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fill && $past(q.fill) && $past(cfg_blank_fill) && $past(cfg_blank_fill, 2))
            |-> (q.data != $past(q.data)));
endmodule

// File: tb/tb_vport_framer.sv
`timescale 1ns/1ps
module tb_vport_framer;
    localparam int WD_CYCLES = 200000;
    localparam int REC_N     = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic       in_field = 1'b0, in_vblank = 1'b0;
    logic       cfg_pulse_mode = 1'b0, cfg_code_en = 1'b0, cfg_blank_fill = 1'b1;
    logic [7:0] out_data;
    logic       out_qual, out_href, out_vref;

    int checks = 0;
    int fails  = 0;
    int ecount = 0;
    bit done   = 1'b0;

    logic [7:0] rd [REC_N];
    logic       rq [REC_N];
    logic       rh [REC_N];
    logic       rv [REC_N];

    vport_framer dut (
        .clk (clk), .rst_n (rst_n),
        .in_data (in_data), .in_valid (in_valid), .in_sol (in_sol), .in_eol (in_eol),
        .in_field (in_field), .in_vblank (in_vblank),
        .cfg_pulse_mode (cfg_pulse_mode), .cfg_code_en (cfg_code_en),
        .cfg_blank_fill (cfg_blank_fill),
        .out_data (out_data), .out_qual (out_qual), .out_href (out_href), .out_vref (out_vref)
    );

    always #10 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    always @(negedge clk) begin
        if (ecount < REC_N) begin
            rd[ecount] = out_data;
            rq[ecount] = out_qual;
            rh[ecount] = out_href;
            rv[ecount] = out_vref;
        end
    end

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_alt(input string tag, input logic [7:0] prev, input logic [7:0] cur);
        checks++;
        if (!((prev == 8'h80 && cur == 8'h10) || (prev == 8'h10 && cur == 8'h80))) begin
            fails++;
            $display("FAIL %s: actual %h after %h expected the other of 80/10", tag, cur, prev);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0; in_data = 8'h00;
        end
    endtask

    // drives one line; k = edge sampling the first byte, e = edge sampling the last
    task automatic send_line(input int len, input int gap_after, input logic f, input logic vb,
                             input logic [7:0] base, output int k, output int e);
        k = 0; e = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sol = (i == 0); in_eol = (i == len - 1);
            in_field = f; in_vblank = vb; in_data = base + 8'(i);
            if (i == 0) k = ecount + 1;
            if (i == len - 1) e = ecount + 1;
            if (i == gap_after && i < len - 1) idle(1);
        end
    endtask

    task automatic t_reset();
        int rel;
        repeat (3) @(negedge clk);
        chk8("R1 reset data", out_data, 8'h00);
        chk1("R1 reset qual", out_qual, 1'b0);
        chk1("R1 reset href", out_href, 1'b0);
        chk1("R1 reset vref", out_vref, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        rel = ecount + 1;
        idle(4);
        chk8("R11 first filler after reset", rd[rel], 8'h80);
        chk8("R11 second filler after reset", rd[rel+1], 8'h10);
    endtask

    task automatic t_plain();
        int k, e;
        cfg_blank_fill = 1'b0; cfg_code_en = 1'b0; cfg_pulse_mode = 1'b0;
        idle(12);
        send_line(4, -1, 1'b0, 1'b0, 8'h40, k, e);
        idle(12);
        for (int i = 0; i < 4; i++) begin
            chk8("R2 data byte", rd[k+4+i], 8'h40 + 8'(i));
            chk1("R2 qualifier on data", rq[k+4+i], 1'b1);
            chk1("R3 href high over line", rh[k+4+i], 1'b1);
        end
        chk1("R2 qualifier before line", rq[k+3], 1'b0);
        chk1("R3 href before line", rh[k+3], 1'b0);
        chk1("R3 href after line", rh[e+5], 1'b0);
        chk1("R4 vref before active line", rv[k+3], 1'b0);
        chk1("R4 vref rises on active line", rv[k+4], 1'b1);
        chk8("R9 no start code when disabled", rd[k+3], 8'h00);
        chk8("R10 zero filler after line", rd[e+5], 8'h00);
        chk8("R10 zero filler later", rd[e+8], 8'h00);
    endtask

    task automatic t_codes();
        int k, e;
        cfg_code_en = 1'b1;
        send_line(3, -1, 1'b0, 1'b0, 8'h20, k, e);
        idle(12);
        chk8("R6 start code byte 0", rd[k], 8'hFF);
        chk8("R6 start code byte 1", rd[k+1], 8'h00);
        chk8("R6 start code byte 2", rd[k+2], 8'h00);
        chk8("R8 start XY F0 V0", rd[k+3], 8'h80);
        chk1("R6 qualifier low in start code", rq[k+1], 1'b0);
        chk1("R6 href low in start code", rh[k+3], 1'b0);
        chk8("R2 first byte after start code", rd[k+4], 8'h20);
        chk8("R7 end code byte 0", rd[e+5], 8'hFF);
        chk8("R7 end code byte 2", rd[e+7], 8'h00);
        chk8("R8 end XY F0 V0", rd[e+8], 8'h9D);
        chk1("R7 qualifier low in end code", rq[e+8], 1'b0);
        chk8("R10 zero filler after end code", rd[e+9], 8'h00);
    endtask

    task automatic t_blank_line();
        int k, e;
        send_line(2, -1, 1'b1, 1'b1, 8'h60, k, e);
        idle(12);
        chk8("R8 start XY F1 V1", rd[k+3], 8'hEC);
        chk8("R8 end XY F1 V1", rd[e+8], 8'hF1);
        chk1("R4 vref held before blank line", rv[k+3], 1'b1);
        chk1("R4 vref falls on blank line", rv[k+4], 1'b0);
    endtask

    task automatic t_pulses();
        int k, e, k2, e2;
        cfg_code_en = 1'b0; cfg_pulse_mode = 1'b1;
        idle(4);
        send_line(3, -1, 1'b0, 1'b0, 8'h70, k, e);
        idle(12);
        send_line(3, -1, 1'b0, 1'b0, 8'h78, k2, e2);
        idle(12);
        chk1("R5 href pulse", rh[k+4], 1'b1);
        chk1("R5 href pulse ends", rh[k+5], 1'b0);
        chk1("R5 href low later in line", rh[k+6], 1'b0);
        chk1("R5 vref pulse", rv[k+4], 1'b1);
        chk1("R5 vref pulse ends", rv[k+5], 1'b0);
        chk1("R5 href pulse second line", rh[k2+4], 1'b1);
        chk1("R5 no vref pulse while gate stays high", rv[k2+4], 1'b0);
    endtask

    task automatic t_gap_fill();
        int k, e;
        cfg_pulse_mode = 1'b0; cfg_blank_fill = 1'b1;
        idle(6);
        send_line(4, 1, 1'b0, 1'b0, 8'h90, k, e);
        idle(12);
        chk1("R3 href held over gap", rh[k+6], 1'b1);
        chk1("R2 qualifier low in gap", rq[k+6], 1'b0);
        chk8("R2 byte after gap", rd[k+7], 8'h92);
        chk_alt("R11 gap filler follows previous filler", rd[k+3], rd[k+6]);
        chk_alt("R11 filler after line follows gap", rd[k+6], rd[e+5]);
        chk_alt("R11 consecutive fillers", rd[e+5], rd[e+6]);
    endtask

    task automatic t_fill_codes();
        int k, e;
        cfg_code_en = 1'b1;
        idle(4);
        send_line(3, -1, 1'b0, 1'b0, 8'hA0, k, e);
        idle(12);
        chk_alt("R11 filler resumes across codes", rd[k-1], rd[e+9]);
        chk_alt("R11 filler continues after codes", rd[e+9], rd[e+10]);
    endtask

    task automatic t_one_byte();
        int k, e;
        cfg_blank_fill = 1'b0;
        idle(4);
        send_line(1, -1, 1'b0, 1'b0, 8'h5A, k, e);
        idle(12);
        chk8("R8 one-byte line start XY", rd[k+3], 8'h80);
        chk8("R2 one-byte line data", rd[k+4], 8'h5A);
        chk1("R3 one-byte line href", rh[k+4], 1'b1);
        chk8("R7 one-byte line end code starts", rd[k+5], 8'hFF);
        chk1("R3 href falls after one byte", rh[k+5], 1'b0);
        chk8("R8 one-byte line end XY", rd[k+8], 8'h9D);
    endtask

    task automatic t_back_to_back();
        int ka, ea, kb, eb;
        idle(4);
        send_line(2, -1, 1'b0, 1'b0, 8'hB0, ka, ea);
        idle(8);
        send_line(2, -1, 1'b1, 1'b0, 8'hC0, kb, eb);
        idle(12);
        chk8("R12 end code last byte", rd[ea+8], 8'h9D);
        chk8("R12 next start code adjacent", rd[ea+9], 8'hFF);
        chk8("R8 start XY F1 V0", rd[ea+12], 8'hC7);
        chk1("R12 qualifier low between codes", rq[ea+9], 1'b0);
        chk8("R12 next line data", rd[ea+13], 8'hC0);
        chk1("R12 next line qualifier", rq[ea+13], 1'b1);
    endtask

    initial begin
        #(WD_CYCLES * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain();
        t_codes();
        t_blank_line();
        t_pulses();
        t_gap_fill();
        t_fill_codes();
        t_one_byte();
        t_back_to_back();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule